// File: doc/BRIEF.md
# Mode-Configurable Logic Array Output Cell

This block sits between the fixed OR stage of a programmable sum-of-products array and one I/O pin. It takes the OR sum for its row and one extra product term. It then produces three things: the value driven onto the pin, the pin's output enable, and a feedback bit that goes back into the array. It is meant to be instanced once per output row, eight times in a typical device. Every instance shares the device-wide mode inputs and the dedicated clock and enable pins.

A two-bit device mode sets which of the four cell configurations are allowed. Each cell then picks its own configuration and output polarity. The cell can be combinatorial with its output always on, combinatorial with the extra product term acting as output enable, registered, or an input-only pin. The mode decides whether the clock and the enable come from the dedicated pins or from the product term. A configuration that the current mode does not allow switches the cell to output-disabled.

Top module: `pld_out_cell`

## Requirements
- R1: With devMode=0 (simple) and cellCfg=0 (always-on combinatorial), pinOe is 1 and pinOut equals (orSum OR auxTerm) XOR activeLow, with no clock delay.
- R2: With devMode=0 and cellCfg=1 (input pin), pinOe is 0 and fbOut equals pinIn.
- R3: With devMode=1 (complex) and cellCfg=2 (term-enabled combinatorial), pinOut equals orSum XOR activeLow, auxTerm is not part of the sum, and pinOe equals auxTerm.
- R4: A storage bit samples (orSum OR auxTerm) XOR activeLow on every rising clkPin edge while rstSync is low. With devMode=2 (registered) and cellCfg=3 (registered), both pinOut and fbOut show the stored bit.
- R5: With devMode=2 and cellCfg=3, pinOe equals the inverse of the active-low oePinN.
- R6: With devMode=2 and cellCfg=2, the cell behaves as in R3: pinOut is orSum XOR activeLow, and pinOe is auxTerm.
- R7: Only these pairs are legal: mode 0 with cfg 0 or 1, mode 1 with cfg 2, and mode 2 with cfg 2 or 3. Every other pair, including any pair with mode 3, drives pinOe to 0 and passes pinIn to fbOut.
- R8: rstSync high at a rising clkPin edge clears the stored bit to 0. A registered cell then drives pinOut and fbOut low.
- R9: In every configuration except registered-legal (mode 2, cfg 3), fbOut equals pinIn. pinOut carries meaning only while pinOe is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clkPin | input | 1 | Dedicated clock pin for the storage bit |
| rstSync | input | 1 | Synchronous clear of the storage bit, active high |
| devMode | input | 2 | Device-wide mode: 0 simple, 1 complex, 2 registered, 3 unused |
| cellCfg | input | 2 | Cell configuration: 0 comb-on, 1 input, 2 comb-term-enable, 3 registered |
| activeLow | input | 1 | 1 inverts the sum before output and storage |
| orSum | input | 1 | OR of the row's product terms |
| auxTerm | input | 1 | Extra product term: adds to the sum or serves as enable |
| oePinN | input | 1 | Dedicated output enable pin, active low |
| pinIn | input | 1 | Value read back from the pad |
| pinOut | output | 1 | Value driven toward the pad |
| pinOe | output | 1 | Pad output enable |
| fbOut | output | 1 | Feedback bit into the array |

## Verification
If the mode decoder picks the wrong path, the fault shows at the pins in the same cycle. The enable is wrong, the extra term is added to the sum or left out when it should not be, or feedback comes from the wrong source. If the storage bit holds a wrong value, a registered cell shows it on pinOut and fbOut one clkPin edge after the inputs that should have set it. A reset that fails shows on the first edge after rstSync is released. The bench walks every mode, configuration and input pattern, so each of these faults shows up within the cycle in which it occurs.

// File: rtl/pld_cell_pkg.sv
package pld_cell_pkg;

  typedef enum logic [1:0] {
    DEV_SIMPLE     = 2'd0,
    DEV_COMPLEX    = 2'd1,
    DEV_REGISTERED = 2'd2,
    DEV_UNUSED     = 2'd3
  } devMode_t;

  typedef enum logic [1:0] {
    CFG_COMB_ON  = 2'd0,
    CFG_INPUT    = 2'd1,
    CFG_COMB_PT  = 2'd2,
    CFG_REG      = 2'd3
  } cellCfg_t;

  typedef enum logic [1:0] {
    OE_OFF = 2'd0,
    OE_ON  = 2'd1,
    OE_PT  = 2'd2,
    OE_PIN = 2'd3
  } oeSrc_t;

  // strobes from decoder to datapath
  typedef struct packed {
    logic   legal;
    logic   regSel;
    logic   sumAddAux;
    oeSrc_t oeSrc;
  } cellCtl_t;

endpackage

// File: rtl/pld_cell_ctrl.sv
module pld_cell_ctrl
  import pld_cell_pkg::*;
(
  input  logic [1:0] devMode,
  input  logic [1:0] cellCfg,
  output cellCtl_t   ctl
);

  always_comb begin
    ctl.legal     = 1'b0;
    ctl.regSel    = 1'b0;
    ctl.sumAddAux = 1'b0;
    ctl.oeSrc     = OE_OFF;
    case (devMode)
      DEV_SIMPLE: begin
        if (cellCfg == CFG_COMB_ON) begin
          ctl.legal     = 1'b1;
          ctl.sumAddAux = 1'b1;
          ctl.oeSrc     = OE_ON;
        end else if (cellCfg == CFG_INPUT) begin
          ctl.legal = 1'b1;
        end
      end
      DEV_COMPLEX: begin
        if (cellCfg == CFG_COMB_PT) begin
          ctl.legal = 1'b1;
          ctl.oeSrc = OE_PT;
        end
      end
      DEV_REGISTERED: begin
        if (cellCfg == CFG_REG) begin
          ctl.legal     = 1'b1;
          ctl.regSel    = 1'b1;
          ctl.sumAddAux = 1'b1;
          ctl.oeSrc     = OE_PIN;
        end else if (cellCfg == CFG_COMB_PT) begin
          ctl.legal = 1'b1;
          ctl.oeSrc = OE_PT;
        end
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/pld_cell_dp.sv
module pld_cell_dp
  import pld_cell_pkg::*;
#(
  parameter logic RESET_VAL = 1'b0
) (
  input  logic     clkPin,
  input  logic     rstSync,
  input  cellCtl_t ctl,
  input  logic     activeLow,
  input  logic     orSum,
  input  logic     auxTerm,
  input  logic     oePinN,
  input  logic     pinIn,
  output logic     pinOut,
  output logic     pinOe,
  output logic     fbOut
);

  logic regD;
  logic regQ;
  logic combVal;
  logic oeRaw;

  // storage input always includes the extra term
  assign regD    = (orSum | auxTerm) ^ activeLow;
  assign combVal = (orSum | (ctl.sumAddAux & auxTerm)) ^ activeLow;

  always_ff @(posedge clkPin) begin
    if (rstSync) regQ <= RESET_VAL;
    else         regQ <= regD;
  end

  always_comb begin
    case (ctl.oeSrc)
      OE_ON:   oeRaw = 1'b1;
      OE_PT:   oeRaw = auxTerm;
      OE_PIN:  oeRaw = ~oePinN;
      default: oeRaw = 1'b0;
    endcase
  end

  assign pinOe  = ctl.legal & oeRaw;
  assign pinOut = ctl.regSel ? regQ : combVal;
  assign fbOut  = ctl.regSel ? regQ : pinIn;

endmodule

// File: rtl/pld_out_cell.sv
module pld_out_cell
  import pld_cell_pkg::*;
(
  input  logic       clkPin,
  input  logic       rstSync,
  input  logic [1:0] devMode,
  input  logic [1:0] cellCfg,
  input  logic       activeLow,
  input  logic       orSum,
  input  logic       auxTerm,
  input  logic       oePinN,
  input  logic       pinIn,
  output logic       pinOut,
  output logic       pinOe,
  output logic       fbOut
);

  cellCtl_t ctl;

  pld_cell_ctrl u_ctrl (
    .devMode (devMode),
    .cellCfg (cellCfg),
    .ctl     (ctl)
  );

  pld_cell_dp #(.RESET_VAL(1'b0)) u_dp (
    .clkPin    (clkPin),
    .rstSync   (rstSync),
    .ctl       (ctl),
    .activeLow (activeLow),
    .orSum     (orSum),
    .auxTerm   (auxTerm),
    .oePinN    (oePinN),
    .pinIn     (pinIn),
    .pinOut    (pinOut),
    .pinOe     (pinOe),
    .fbOut     (fbOut)
  );

  // port-level view used by the checks below
  logic isRegCell;
  logic pairOk;
  logic armed;

  assign isRegCell = (devMode == 2'd2) && (cellCfg == 2'd3);
  assign pairOk = ((devMode == 2'd0) && (cellCfg[1] == 1'b0)) ||
                  ((devMode == 2'd1) && (cellCfg == 2'd2)) ||
                  ((devMode == 2'd2) && (cellCfg[1] == 1'b1));

  always_ff @(posedge clkPin) armed <= ~rstSync;

  // R4
  reg_capture_chk: assert property (@(posedge clkPin) disable iff (rstSync || !armed)
    isRegCell |-> (pinOut == $past((orSum | auxTerm) ^ activeLow)));

  // R5
  reg_oe_chk: assert property (@(posedge clkPin) disable iff (rstSync)
    isRegCell |-> (pinOe == !oePinN));

  // R8
  reset_clear_chk: assert property (@(posedge clkPin) disable iff (rstSync)
    ($fell(rstSync) && isRegCell) |-> (pinOut == 1'b0 && fbOut == 1'b0));

  // R7
  illegal_off_chk: assert property (@(posedge clkPin) disable iff (rstSync)
    !pairOk |-> (pinOe == 1'b0));

  // R9
  fb_pin_chk: assert property (@(posedge clkPin) disable iff (rstSync)
    !isRegCell |-> (fbOut == pinIn));

endmodule

// File: tb/test_pld_out_cell.sv
module test_pld_out_cell;

  logic       clk = 1'b0;
  logic       rstSync;
  logic [1:0] devMode;
  logic [1:0] cellCfg;
  logic       activeLow, orSum, auxTerm, oePinN, pinIn;
  logic       pinOut, pinOe, fbOut;

  int total = 0;
  int bad   = 0;

  typedef struct {
    string tag;
    logic  expOut;
    logic  expOe;
    logic  expFb;
  } expItem_t;

  expItem_t expQ[$];
  event sampleEv;
  logic modelQ;

  always #10 clk = ~clk;

  pld_out_cell i_pld_out_cell (
    .clkPin (clk), .rstSync (rstSync), .devMode (devMode), .cellCfg (cellCfg),
    .activeLow (activeLow), .orSum (orSum), .auxTerm (auxTerm), .oePinN (oePinN),
    .pinIn (pinIn), .pinOut (pinOut), .pinOe (pinOe), .fbOut (fbOut)
  );

  // R4/R8: storage bit model
  always @(posedge clk) modelQ <= rstSync ? 1'b0 : ((orSum | auxTerm) ^ activeLow);

  function automatic string tagOf(input logic [1:0] m, input logic [1:0] c);
    if (m == 2'd0 && c == 2'd0) return "R1";
    if (m == 2'd0 && c == 2'd1) return "R2";
    if (m == 2'd1 && c == 2'd2) return "R3";
    if (m == 2'd2 && c == 2'd3) return "R4";
    if (m == 2'd2 && c == 2'd2) return "R6";
    return "R7";
  endfunction

  // driver: pushes expectations from the requirement table
  task automatic pushExpect();
    expItem_t it;
    it.tag = tagOf(devMode, cellCfg);
    it.expFb = pinIn;            // R9 default
    it.expOe = 1'b0;
    it.expOut = 1'bx;
    case (it.tag)
      "R1": begin it.expOe = 1'b1; it.expOut = (orSum | auxTerm) ^ activeLow; end
      "R3", "R6": begin it.expOe = auxTerm; it.expOut = orSum ^ activeLow; end
      "R4": begin it.expOe = ~oePinN; it.expOut = modelQ; it.expFb = modelQ; end // R5 too
      default: ;
    endcase
    expQ.push_back(it);
    -> sampleEv;
  endtask

  task automatic step(input logic [1:0] m, input logic [1:0] c, input logic inv,
                      input logic s, input logic a, input logic oeN, input logic p);
    @(negedge clk);
    devMode = m; cellCfg = c; activeLow = inv; orSum = s; auxTerm = a;
    oePinN = oeN; pinIn = p;
    #3;
    pushExpect();
    #1;
  endtask

  // monitor
  initial begin
    expItem_t it;
    forever begin
      @(sampleEv);
      while (expQ.size() > 0) begin
        it = expQ.pop_front();
        total++;
        if (pinOe !== it.expOe || fbOut !== it.expFb ||
            (it.expOe === 1'b1 && pinOut !== it.expOut)) begin
          bad++;
          $display("FAIL %s: out=%b oe=%b fb=%b expected out=%b oe=%b fb=%b",
                   it.tag, pinOut, pinOe, fbOut, it.expOut, it.expOe, it.expFb);
        end
      end
    end
  end

  task automatic directCheck(input string tag, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
    end
  endtask

  initial begin
    rstSync = 1'b1; devMode = 2'd2; cellCfg = 2'd3; activeLow = 1'b0;
    orSum = 1'b1; auxTerm = 1'b1; oePinN = 1'b0; pinIn = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    // R8: reset state visible on a registered cell
    directCheck("R8", pinOut, 1'b0);
    directCheck("R8", fbOut, 1'b0);
    rstSync = 1'b0;
    @(posedge clk); #2;
    // R4: captured 1 after release
    directCheck("R4", pinOut, 1'b1);
    // R8: mid-run clear
    @(negedge clk); rstSync = 1'b1;
    @(posedge clk); #2;
    directCheck("R8", pinOut, 1'b0);
    @(negedge clk); rstSync = 1'b0;
    // sweep all modes, configs and input patterns
    for (int m = 0; m < 4; m++)
      for (int c = 0; c < 4; c++)
        for (int v = 0; v < 32; v++)
          step(m[1:0], c[1:0], v[0], v[1], v[2], v[3], v[4]);
    // R4: registered sequence with polarity, held across several edges
    step(2'd2, 2'd3, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
    step(2'd2, 2'd3, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    step(2'd2, 2'd3, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1);
    step(2'd2, 2'd3, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
    #20;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #2000000;
    bad++;
    total++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule